// File: doc/BRIEF.md
# Configurable Logic-Array Register Cell

This block is one output cell of a programmable logic array. It takes a group of product-term bits from the AND plane and ORs them into a sum term. A programmable polarity stage can then invert that sum. The adjusted sum either goes straight to the cell output, or it passes through a flip-flop clocked by the array's shared clock. The flip-flop loads the value in D mode and toggles on a 1 in T mode.

Each cell has an asynchronous clear and an asynchronous set. Each of the two picks its own source: a dedicated product term, the chip-wide reset input, or power-on reset. Power-on reset always clears the flip-flop, whatever the configuration says. The flip-flop state is brought out on its own feedback output. Several cells can therefore be wired back into their own product terms to form a small sequencing state machine.

The configuration word can change at run time. All modes and source selections take effect as soon as they are applied.

Top module: `pldcell_top`

## Requirements
- R1: The polarity-adjusted sum is the OR of all product-term bits, inverted when `cfg_word[2]` is 1. When `cfg_word[1]` (bypass) is 1, `cell_out` equals this sum combinationally.
- R2: In D mode (`cfg_word[0]` = 0), with no asynchronous control active, the flip-flop loads the polarity-adjusted sum on each rising edge of `clk`.
- R3: In T mode (`cfg_word[0]` = 1), with no asynchronous control active, the flip-flop inverts its state on a rising edge when the adjusted sum is 1 and holds its state when the sum is 0.
- R4: `cell_fb` always shows the flip-flop state. When bypass is 0, `cell_out` shows the flip-flop state as well.
- R5: While `por` is high, the flip-flop is 0 at once and stays 0, whatever the configuration and other inputs are.
- R6: The clear source is chosen by `cfg_word[4:3]`: 00 none, 01 `pt_rst`, 10 `gbl_rst`, 11 `por`. While the chosen source is high, the flip-flop is 0 without waiting for a clock edge.
- R7: The set source is chosen by `cfg_word[6:5]` with the same codes. While the chosen source is high and no clear is active, the flip-flop is 1 without waiting for a clock edge.
- R8: When clear and set are active together, the clear wins and the flip-flop is 0.
- R9: An asynchronous input that is not selected as a source, such as `pt_rst` or `gbl_rst` when the code names another source, has no effect on the flip-flop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared array clock, rising edge |
| por | input | 1 | Power-on reset, active high, always clears |
| gbl_rst | input | 1 | Chip-wide reset input, usable as a clear or set source |
| pt_terms | input | NUM_PT | Product-term bits feeding the OR |
| pt_rst | input | 1 | Product term usable as the clear source |
| pt_set | input | 1 | Product term usable as the set source |
| cfg_word | input | 7 | {set_src[1:0], rst_src[1:0], invert, bypass, toggle} |
| cell_out | output | 1 | Cell output: adjusted sum when bypassed, flip-flop state otherwise |
| cell_fb | output | 1 | Flip-flop state for feedback |

## Verification
The bench builds the cell with the default five product terms. This lets it drive each term on its own and in every combination, so the OR stage and the polarity inversion are exercised across the full term width. Each mode and each clear and set source is reached in directed sequences. A long stretch of random configuration and input changes then runs against a behavioural model, which brings in run-time mode switches and overlapping clear and set requests.

// File: rtl/pldcell_pkg.sv
package pldcell_pkg;

   typedef enum logic [1:0] {
      SRC_NONE    = 2'b00,
      SRC_PTERM   = 2'b01,
      SRC_GLOBAL  = 2'b10,
      SRC_POWERON = 2'b11
   } async_src_e;

   typedef struct packed {
      async_src_e set_src;
      async_src_e rst_src;
      logic       invert;
      logic       bypass;
      logic       toggle;
   } cell_cfg_t;

   localparam int CFG_W = $bits(cell_cfg_t);

endpackage

// File: rtl/pldcell_sum.sv
module pldcell_sum #(
   parameter int NUM_PT = 5
) (
   input  logic [NUM_PT-1:0] terms,
   input  logic              invert,
   output logic              sum_pol
);

   logic raw_sum;

   generate
      if (NUM_PT < 1) begin : g_bad
         $error("pldcell_sum: NUM_PT must be at least 1");
      end else if (NUM_PT == 1) begin : g_single
         assign raw_sum = terms[0];
      end else begin : g_wide
         assign raw_sum = |terms;
      end
   endgenerate

   assign sum_pol = raw_sum ^ invert;

endmodule

// File: rtl/pldcell_srcsel.sv
module pldcell_srcsel
   import pldcell_pkg::*;
(
   input  async_src_e sel,
   input  logic       pterm_req,
   input  logic       global_req,
   input  logic       poweron_req,
   output logic       req
);

   always_comb begin
      unique case (sel)
         SRC_PTERM:   req = pterm_req;
         SRC_GLOBAL:  req = global_req;
         SRC_POWERON: req = poweron_req;
         default:     req = 1'b0;
      endcase
   end

endmodule

// File: rtl/pldcell_reg.sv
module pldcell_reg (
   input  logic clk,
   input  logic aclr,
   input  logic aset,
   input  logic toggle,
   input  logic d_in,
   output logic q
);

   logic q_next;

   always_comb begin
      if (toggle) q_next = q ^ d_in;
      else        q_next = d_in;
   end

   always_ff @(posedge clk or posedge aclr or posedge aset) begin
      if (aclr)      q <= 1'b0;
      else if (aset) q <= 1'b1;
      else           q <= q_next;
   end

endmodule

// File: rtl/pldcell_top.sv
module pldcell_top
   import pldcell_pkg::*;
#(
   parameter int NUM_PT = 5
) (
   input  logic              clk,
   input  logic              por,
   input  logic              gbl_rst,
   input  logic [NUM_PT-1:0] pt_terms,
   input  logic              pt_rst,
   input  logic              pt_set,
   input  logic [CFG_W-1:0]  cfg_word,
   output logic              cell_out,
   output logic              cell_fb
);

   cell_cfg_t cfg;
   logic      sum_pol;
   logic      rst_req;
   logic      set_req;
   logic      clr_any;
   logic      set_eff;
   logic      q;

   assign cfg = cell_cfg_t'(cfg_word);

   pldcell_sum #(.NUM_PT(NUM_PT)) sum_i (
      .terms   (pt_terms),
      .invert  (cfg.invert),
      .sum_pol (sum_pol)
   );

   pldcell_srcsel rsel_i (
      .sel         (cfg.rst_src),
      .pterm_req   (pt_rst),
      .global_req  (gbl_rst),
      .poweron_req (por),
      .req         (rst_req)
   );

   pldcell_srcsel ssel_i (
      .sel         (cfg.set_src),
      .pterm_req   (pt_set),
      .global_req  (gbl_rst),
      .poweron_req (por),
      .req         (set_req)
   );

   // clear dominates: power-on always, then the selected clear source
   assign clr_any = por | rst_req;
   assign set_eff = set_req & ~clr_any;

   pldcell_reg reg_i (
      .clk    (clk),
      .aclr   (clr_any),
      .aset   (set_eff),
      .toggle (cfg.toggle),
      .d_in   (sum_pol),
      .q      (q)
   );

   assign cell_out = cfg.bypass ? sum_pol : q;
   assign cell_fb  = q;

endmodule

// File: rtl/pldcell_chk.sv
module pldcell_chk
   import pldcell_pkg::*;
#(
   parameter int NUM_PT = 5
) (
   input logic              clk,
   input logic              por,
   input logic              gbl_rst,
   input logic [NUM_PT-1:0] pt_terms,
   input logic              pt_rst,
   input logic              pt_set,
   input logic [CFG_W-1:0]  cfg_word,
   input logic              cell_out,
   input logic              cell_fb
);

   logic exp_sum;
   logic clr_seen;
   logic set_seen;
   logic exp_next;

   assign exp_sum  = (pt_terms != '0) ^ cfg_word[2];
   assign clr_seen = (cfg_word[4:3] == 2'b01 && pt_rst) ||
                     (cfg_word[4:3] == 2'b10 && gbl_rst);
   assign set_seen = (cfg_word[6:5] == 2'b01 && pt_set) ||
                     (cfg_word[6:5] == 2'b10 && gbl_rst);
   assign exp_next = cfg_word[0] ? (cell_fb ^ exp_sum) : exp_sum;

   a_r5_por_clears: assert property (@(posedge clk)
      por |-> (cell_fb == 1'b0));

   a_r1_bypass_sum: assert property (@(posedge clk) disable iff (por)
      cfg_word[1] |-> (cell_out == exp_sum));

   a_r4_reg_out: assert property (@(posedge clk) disable iff (por)
      !cfg_word[1] |-> (cell_out == cell_fb));

   a_r6_r8_clear: assert property (@(posedge clk) disable iff (por)
      clr_seen |-> (cell_fb == 1'b0));

   a_r7_preset: assert property (@(posedge clk) disable iff (por)
      (set_seen && !clr_seen) |-> (cell_fb == 1'b1));

   // R2 and R3: clocked update when no asynchronous control is active
   a_r2_r3_update: assert property (@(posedge clk) disable iff (por)
      (!clr_seen && !set_seen) |=>
         (clr_seen || set_seen || cell_fb == $past(exp_next)));

endmodule

bind pldcell_top pldcell_chk #(.NUM_PT(NUM_PT)) chk_i (
   .clk      (clk),
   .por      (por),
   .gbl_rst  (gbl_rst),
   .pt_terms (pt_terms),
   .pt_rst   (pt_rst),
   .pt_set   (pt_set),
   .cfg_word (cfg_word),
   .cell_out (cell_out),
   .cell_fb  (cell_fb)
);

// File: tb/pldcell_top_tb_top.sv
module pldcell_top_tb_top;

   localparam int NPT = 5;

   logic           clk      = 1'b0;
   logic           por      = 1'b0;
   logic           gbl_rst  = 1'b0;
   logic [NPT-1:0] pt_terms = '0;
   logic           pt_rst   = 1'b0;
   logic           pt_set   = 1'b0;
   logic [6:0]     cfg_word = '0;
   logic           cell_out;
   logic           cell_fb;

   int   errors = 0;
   int   checks = 0;
   bit   done   = 0;
   logic mq     = 1'b0;

   always #4 clk = ~clk;

   pldcell_top #(.NUM_PT(NPT)) dut_i (
      .clk      (clk),
      .por      (por),
      .gbl_rst  (gbl_rst),
      .pt_terms (pt_terms),
      .pt_rst   (pt_rst),
      .pt_set   (pt_set),
      .cfg_word (cfg_word),
      .cell_out (cell_out),
      .cell_fb  (cell_fb)
   );

   function automatic bit pick(input logic [1:0] code, input logic ptv,
                               input logic gv, input logic pov);
      case (code)
         2'b01:   return bit'(ptv);
         2'b10:   return bit'(gv);
         2'b11:   return bit'(pov);
         default: return 1'b0;
      endcase
   endfunction

   function automatic bit m_sum();
      return bit'((pt_terms != '0) ^ cfg_word[2]);
   endfunction

   function automatic bit m_clr();
      return bit'(por) || pick(cfg_word[4:3], pt_rst, gbl_rst, por);
   endfunction

   function automatic bit m_set();
      return pick(cfg_word[6:5], pt_set, gbl_rst, por);
   endfunction

   task automatic check(input string tag, input string what,
                        input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%b expected=%b at %0t",
                  tag, what, act, exp, $time);
      end
   endtask

   task automatic compare(input string tag);
      string ft;
      if (tag != "")          ft = tag;
      else if (por)           ft = "R5";
      else if (m_clr())       ft = m_set() ? "R8" : "R6";
      else if (m_set())       ft = "R7";
      else if (cfg_word[0])   ft = "R3";
      else                    ft = "R2";
      check(ft, "cell_fb", cell_fb, mq);
      if (cfg_word[1]) check("R1", "cell_out(bypass)", cell_out, m_sum());
      else             check("R4", "cell_out(reg)", cell_out, mq);
   endtask

   task automatic model_async();
      if (m_clr())      mq = 1'b0;
      else if (m_set()) mq = 1'b1;
   endtask

   task automatic cycle(input logic [6:0] c, input logic [NPT-1:0] p,
                        input logic pr, input logic ps, input logic g,
                        input logic po, input string tag);
      @(negedge clk);
      cfg_word = c; pt_terms = p; pt_rst = pr; pt_set = ps;
      gbl_rst = g; por = po;
      #1;
      model_async();
      compare(tag);
      @(posedge clk);
      if (!m_clr() && !m_set())
         mq = cfg_word[0] ? (mq ^ m_sum()) : m_sum();
      #1;
      compare(tag);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #1 por = 1'b1;
      mq = 1'b0;
      // reset state, with inputs that would otherwise set the flop (R5)
      cycle(7'b10_00_0_0_0, 5'b00001, 0, 0, 1, 1, "R5");
      cycle(7'b01_00_1_0_1, 5'b11111, 0, 1, 0, 1, "R5");
      cycle(7'b11_00_0_0_0, 5'b00000, 0, 0, 0, 1, "R5"); // set src = por, masked
      // D mode (R2)
      cycle(7'b00_00_0_0_0, 5'b00100, 0, 0, 0, 0, "R2");
      cycle(7'b00_00_0_0_0, 5'b00000, 0, 0, 0, 0, "R2");
      cycle(7'b00_00_1_0_0, 5'b00000, 0, 0, 0, 0, "R2");
      // bypass: each term alone, both polarities (R1)
      for (int i = 0; i < NPT; i++) begin
         cycle(7'b00_00_0_1_0, 5'(1 << i), 0, 0, 0, 0, "");
         cycle(7'b00_00_1_1_0, 5'(1 << i), 0, 0, 0, 0, "");
      end
      cycle(7'b00_00_1_1_0, 5'b00000, 0, 0, 0, 0, "");
      // T mode: toggles on 1, holds on 0 (R3)
      cycle(7'b00_00_0_0_0, 5'b00000, 0, 0, 0, 0, "R3");
      cycle(7'b00_00_0_0_1, 5'b10000, 0, 0, 0, 0, "R3");
      cycle(7'b00_00_0_0_1, 5'b01000, 0, 0, 0, 0, "R3");
      cycle(7'b00_00_0_0_1, 5'b00000, 0, 0, 0, 0, "R3");
      cycle(7'b00_00_0_0_1, 5'b11000, 0, 0, 0, 0, "R3");
      // preset from product term, then from global (R7)
      cycle(7'b01_00_0_0_0, 5'b00000, 0, 1, 0, 0, "R7");
      cycle(7'b10_00_0_0_1, 5'b00000, 0, 0, 1, 0, "R7");
      // clear from product term and global (R6)
      cycle(7'b00_01_1_0_0, 5'b00000, 1, 0, 0, 0, "R6");
      cycle(7'b00_00_1_0_0, 5'b00000, 0, 0, 0, 0, "R2");
      cycle(7'b00_10_0_0_0, 5'b11111, 0, 0, 1, 0, "R6");
      // unselected sources ignored (R9)
      cycle(7'b00_10_1_0_0, 5'b00000, 1, 0, 0, 0, "R9");
      cycle(7'b01_10_0_0_0, 5'b00000, 0, 0, 0, 0, "R9");
      cycle(7'b00_01_0_0_0, 5'b00001, 0, 1, 1, 0, "R9");
      cycle(7'b10_00_0_0_0, 5'b00000, 1, 1, 0, 0, "R9");
      // clear beats set (R8)
      cycle(7'b01_01_1_0_0, 5'b00000, 1, 1, 0, 0, "R8");
      cycle(7'b10_10_1_0_1, 5'b11111, 0, 0, 1, 0, "R8");
      cycle(7'b01_10_0_0_0, 5'b00001, 0, 1, 1, 0, "R8");
      // random run against the model
      for (int n = 0; n < 4000; n++) begin
         logic [6:0] rc;
         rc = 7'($urandom);
         cycle(rc, 5'($urandom), ($urandom % 6) == 0, ($urandom % 6) == 0,
               ($urandom % 8) == 0, ($urandom % 50) == 0, "");
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule